// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block produces the serial clock of a SPI flash master from the reference clock that feeds it. A 3-bit divisor code selects a power-of-two ratio between /2 and /256. Two mode bits set the clock polarity and phase. Besides the clock itself, the block issues one-cycle launch and capture pulses. They mark the reference-clock cycle in which a neighbouring shift register should drive the next data bit or sample the incoming one.

A transfer runs for as long as the transfer-active input is held high. The divisor and mode settings are taken when a transfer starts. The clock always finishes the serial period it is in, so every bit lasts exactly one full period.

The block also drives two active-low chip selects, one per memory. They are forced directly from a control bit, and a second control bit picks which memory the asserted select reaches.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: During and right after synchronous reset, `sclk_o` equals `cpol_i`, `launch_o` and `capture_o` are low and both chip selects are high.
- R2: While no transfer runs, `sclk_o` rests at the `cpol_i` level sampled on the previous clock edge.
- R3: For divisor code c, each half of the serial period lasts 2^c reference cycles, so the full period is 2 << c cycles. Code 0 gives /2 and code 7 gives /256.
- R4: With `cpha_i`=0, `capture_o` pulses in the cycle of each leading SCLK edge. `launch_o` pulses in the first cycle of the transfer and at every trailing edge except the final one.
- R5: With `cpha_i`=1, `launch_o` pulses at each leading SCLK edge and `capture_o` at each trailing edge.
- R6: While a transfer runs, `sclk_o` leaves the latched polarity level at each leading edge and returns to it at each trailing edge.
- R7: A transfer starts at the first clock edge at which the block is idle with `enable_i` and `xfer_active_i` both high. It ends at a trailing edge at which `xfer_active_i` is low, so only whole periods are produced.
- R8: Divisor code, polarity and phase are captured at the start of a transfer. Changes to them during the transfer have no effect on it.
- R9: With `enable_i` low, no transfer starts. Dropping `enable_i` during a transfer returns the block to idle at the next edge, with no pulses.
- R10: `cs_n_o` is registered (one cycle of latency). With `cs_force_n_i`=1 both bits are high. With `cs_force_n_i`=0 only bit `mem_sel_i` is low: bit 0 is the lower memory and bit 1 the upper.
- R11: `launch_o` and `capture_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable_i | input | 1 | Block enable; low forces idle |
| xfer_active_i | input | 1 | High while a transfer should run |
| div_code_i | input | 3 | Divisor code, ratio 2 << code |
| cpol_i | input | 1 | Clock polarity (idle level) |
| cpha_i | input | 1 | Clock phase |
| cs_force_n_i | input | 1 | Chip-select control, 0 asserts |
| mem_sel_i | input | 1 | Memory select, 0 lower, 1 upper |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle pulse: drive next data bit |
| capture_o | output | 1 | One-cycle pulse: sample data bit |
| cs_n_o | output | 2 | Active-low chip selects |

## Verification
The hardest case to reach is a settings change in the middle of a transfer. The block must ignore it, but that is only visible if the pulse spacing is checked against the code latched at start. In every run of the sweep, the bench flips the divisor code to its complement one cycle after the start. It then checks each edge and pulse cycle against the original code, for all eight codes and all four modes. The transfer end is forced by dropping the active input between the second and third trailing edges. A separate run drops the enable input half-way through a period to reach the abort path.

// File: rtl/sclk_presc_pkg.sv
// Package: shared widths and the settings record captured at transfer start.
// Assumes: the divisor code is a power-of-two exponent (ratio 2 << code).
package sclk_presc_pkg;
    localparam int DIV_CODE_W = 3;

    typedef struct packed {
        logic [DIV_CODE_W-1:0] code;
        logic                  cpol;
        logic                  cpha;
    } xfer_cfg_t;
endpackage

// File: rtl/sclk_half_counter.sv
// Module: counts reference cycles within one half of the serial period.
// Raises tick_o in the last cycle of each half (2^code cycles long).
// Assumes: run_i is the registered running state; the count is held at 0 while idle.
module sclk_half_counter #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;

    // Terminal count: 2^code - 1, built as a mask of code low-order ones.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            term[i] = (i < int'(code_i));
        end
    end

    assign tick_o = run_i && (cnt_q == term);

    // Advance the half-period count; clear on idle and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= term)); // R3
endmodule

// File: rtl/sclk_edge_engine.sv
// Module: run/idle control, SCLK level, and launch/capture pulse timing.
// Captures the settings at transfer start; stops only at a trailing edge.
// Assumes: tick_i comes from a half counter running on cfg_o.code.
module sclk_edge_engine
    import sclk_presc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       active_i,
    input  xfer_cfg_t  cfg_i,
    input  logic       tick_i,
    output logic       running_o,
    output xfer_cfg_t  cfg_o,
    output logic       sclk_o,
    output logic       launch_o,
    output logic       capture_o
);
    logic second_half_q;

    // Sequence idle -> running -> idle and emit edge-aligned pulses.
    always_ff @(posedge clk) begin
        launch_o  <= 1'b0;
        capture_o <= 1'b0;
        if (!rst_n) begin
            running_o     <= 1'b0;
            second_half_q <= 1'b0;
            cfg_o         <= '0;
            sclk_o        <= cfg_i.cpol;
        end else if (!enable_i) begin
            running_o     <= 1'b0;
            second_half_q <= 1'b0;
            sclk_o        <= cfg_i.cpol;
        end else if (!running_o) begin
            second_half_q <= 1'b0;
            sclk_o        <= cfg_i.cpol;
            if (active_i) begin
                running_o <= 1'b1;
                cfg_o     <= cfg_i;
                launch_o  <= ~cfg_i.cpha;
            end
        end else if (tick_i) begin
            if (!second_half_q) begin
                second_half_q <= 1'b1;
                sclk_o        <= ~cfg_o.cpol;
                launch_o      <= cfg_o.cpha;
                capture_o     <= ~cfg_o.cpha;
            end else begin
                second_half_q <= 1'b0;
                sclk_o        <= cfg_o.cpol;
                capture_o     <= cfg_o.cpha;
                if (!active_i) begin
                    running_o <= 1'b0;
                end else begin
                    launch_o  <= ~cfg_o.cpha;
                end
            end
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && $past(running_o)) |-> $stable(cfg_o)); // R8
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !$past(running_o)) |-> ($past(active_i) && $past(enable_i))); // R7
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!running_o && !launch_o && !capture_o)); // R9
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_o && capture_o)); // R11
endmodule

// File: rtl/flash_cs_driver.sv
// Module: registered active-low chip selects forced from a control bit.
// Assumes: a select value outside the memory count asserts nothing.
module flash_cs_driver #(
    parameter int NUM_CS = 2,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_n_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [NUM_CS-1:0] cs_n_o
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        // Drive one select low only when forced and addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cs_n_o[g] <= 1'b1;
            end else begin
                cs_n_o[g] <= force_n_i || (int'(sel_i) != g);
            end
        end
    end

    AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R10
endmodule

// File: rtl/spi_sclk_prescaler.sv
// Module: top of the serial clock prescaler for a SPI flash master.
// Joins the half-period counter, the edge engine and the chip-select driver.
// Assumes: all inputs are synchronous to clk.
module spi_sclk_prescaler
    import sclk_presc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable_i,
    input  logic                  xfer_active_i,
    input  logic [DIV_CODE_W-1:0] div_code_i,
    input  logic                  cpol_i,
    input  logic                  cpha_i,
    input  logic                  cs_force_n_i,
    input  logic                  mem_sel_i,
    output logic                  sclk_o,
    output logic                  launch_o,
    output logic                  capture_o,
    output logic [1:0]            cs_n_o
);
    xfer_cfg_t cfg_in;
    xfer_cfg_t cfg_run;
    logic      running;
    logic      tick;

    assign cfg_in = '{code: div_code_i, cpol: cpol_i, cpha: cpha_i};

    sclk_half_counter #(.CODE_W(DIV_CODE_W)) half_cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .code_i (cfg_run.code),
        .tick_o (tick)
    );

    sclk_edge_engine edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .active_i  (xfer_active_i),
        .cfg_i     (cfg_in),
        .tick_i    (tick),
        .running_o (running),
        .cfg_o     (cfg_run),
        .sclk_o    (sclk_o),
        .launch_o  (launch_o),
        .capture_o (capture_o)
    );

    flash_cs_driver #(.NUM_CS(2)) cs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_n_i (cs_force_n_i),
        .sel_i     (mem_sel_i),
        .cs_n_o    (cs_n_o)
    );

    AST_CAPTURE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> (sclk_o != $past(sclk_o))); // R4
endmodule

// File: tb/spi_sclk_prescaler_tb_top.sv
`timescale 1ns/1ps
module spi_sclk_prescaler_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic       xfer_active_i = 1'b0;
    logic [2:0] div_code_i = 3'd0;
    logic       cpol_i = 1'b1;
    logic       cpha_i = 1'b0;
    logic       cs_force_n_i = 1'b1;
    logic       mem_sel_i = 1'b0;
    logic       sclk_o, launch_o, capture_o;
    logic [1:0] cs_n_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_sclk_prescaler dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .xfer_active_i(xfer_active_i),
        .div_code_i(div_code_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
        .cs_force_n_i(cs_force_n_i), .mem_sel_i(mem_sel_i),
        .sclk_o(sclk_o), .launch_o(launch_o), .capture_o(capture_o), .cs_n_o(cs_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One transfer of three serial periods; the code is flipped mid-transfer.
    task automatic run_xfer(input int code, input int pol, input int pha);
        int h = 1 << code;
        @(negedge clk);
        div_code_i = 3'(code); cpol_i = 1'(pol); cpha_i = 1'(pha);
        enable_i = 1'b1; xfer_active_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 idle level", int'(sclk_o), pol);
        xfer_active_i = 1'b1;
        @(posedge clk);
        for (int i = 0; i <= 6 * h + 2; i++) begin
            @(negedge clk);
            begin
                int ph  = (i < 6 * h) ? ((i / h) % 2) : 0;
                int exs = pol ^ ph;
                int exc, exl;
                if (pha == 0) begin
                    exc = (i < 6 * h && (i % (2 * h)) == h) ? 1 : 0;
                    exl = (i < 6 * h && (i % (2 * h)) == 0) ? 1 : 0;
                end else begin
                    exc = (i > 0 && i <= 6 * h && (i % (2 * h)) == 0) ? 1 : 0;
                    exl = (i < 6 * h && (i % (2 * h)) == h) ? 1 : 0;
                end
                check("R3/R6/R8 sclk level", int'(sclk_o), exs);
                check(pha == 0 ? "R4 capture" : "R5 capture", int'(capture_o), exc);
                check(pha == 0 ? "R4 launch" : "R5 launch", int'(launch_o), exl);
                check("R11 pulse exclusive", int'(launch_o && capture_o), 0);
            end
            if (i == 0) div_code_i = ~3'(code);      // R8: ignored until next start
            if (i == 5 * h) xfer_active_i = 1'b0;    // R7: end after third period
        end
        div_code_i = 3'(code);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sclk in reset", int'(sclk_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sclk after reset", int'(sclk_o), 1);
        check("R1 launch after reset", int'(launch_o), 0);
        check("R1 capture after reset", int'(capture_o), 0);
        check("R1 cs_n after reset", int'(cs_n_o), 3);

        // R3 R4 R5 R6 R7 R8: sweep all codes and modes
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                run_xfer(c, m >> 1, m & 1);
            end
        end

        // R9: abort mid-period, then no start while disabled
        @(negedge clk);
        div_code_i = 3'd2; cpol_i = 1'b0; cpha_i = 1'b0; enable_i = 1'b1;
        xfer_active_i = 1'b1;
        @(posedge clk);
        repeat (5) @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        check("R9 abort sclk", int'(sclk_o), 0);
        check("R9 abort launch", int'(launch_o), 0);
        check("R9 abort capture", int'(capture_o), 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R9 no start while disabled", int'(sclk_o | launch_o | capture_o), 0);
        end
        enable_i = 1'b1;
        @(negedge clk);
        check("R7 restart launch", int'(launch_o), 1);
        enable_i = 1'b0; xfer_active_i = 1'b0;
        @(negedge clk);
        check("R9 idle again", int'(sclk_o), 0);

        // R2: idle level follows polarity input with one cycle latency
        cpol_i = 1'b1;
        @(negedge clk);
        check("R2 idle follows cpol", int'(sclk_o), 1);

        // R10: chip-select combinations
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 2; s++) begin
                cs_force_n_i = 1'(f); mem_sel_i = 1'(s);
                @(negedge clk);
                check("R10 cs_n", int'(cs_n_o), (f == 1) ? 3 : ((s == 1) ? 1 : 2));
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule